// File: doc/BRIEF.md
# Fracturable Lookup Table with Mode-Gated Inputs

This block is a K-input lookup table. The K inputs steer a binary multiplexer tree, and the leaves of that tree are 2^K configuration bits, so any Boolean function of the inputs can be stored. Each input has a fixed gating tag chosen at elaboration: pass, force-low or force-high. A force-low input is ANDed with a mode bit, so a cleared mode bit pins it to 0. A force-high input is ORed with a mode bit, so a set mode bit pins it to 1. By pinning the top input, one physical table can serve as two independent (K-1)-input functions. The first output gives the full-table result. The second output is taken from the subtree over the lower half of the table.

The truth table and the mode bits form one configuration word, with the table in the low positions and the mode bits above it. The word is loaded through a serial shift chain while a shift enable is high. When the enable is low the stored word is frozen. Reset clears every configuration bit. A parameter set in which the number of mode bits does not match the number of gated inputs is rejected at elaboration. A non-fracturable build, which has no gated inputs and no mode bits, ties the second output low.

Top module: `fraclut_top`

## Requirements
- R1: With every gated input released, `outFull` equals configuration bit `lutIn` of the truth table (bits 0 to 2^K-1 of the word, index formed with `lutIn[0]` as LSB).
- R2: A force-low input reads as 0 inside the table while its mode bit is 0, and it reads as its pin value while its mode bit is 1.
- R3: A force-high input reads as 1 inside the table while its mode bit is 1, and it reads as its pin value while its mode bit is 0.
- R4: Mode bits are given to gated inputs in ascending input index, starting at word bit 2^K. With the default tags, input 2 is force-high and uses mode bit 0 (word bit 16), and input 3 is force-low and uses mode bit 1 (word bit 17).
- R5: `outHalf` equals truth-table bit `lutIn[K-2:0]` (after gating), taken from the lower half of the table, independent of input K-1.
- R6: Each clock with `cfgEn` high shifts `cfgIn` into the top word bit and moves every bit down by one. After 2^K+MODE_W shifts, the first bit sent is word bit 0.
- R7: While `cfgEn` is low, `cfgIn` has no effect: the stored word, and with it both outputs and `cfgOut`, stays unchanged.
- R8: `cfgOut` always shows word bit 0, so the bits of the old word leave the chain LSB first while a new word is shifted in.
- R9: While reset is held and after it is released, the word is all zero: both outputs are 0 for every input pattern and `cfgOut` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration chain clock |
| rstN | input | 1 | Asynchronous active-low reset, clears the word |
| cfgEn | input | 1 | Shift enable for the configuration chain |
| cfgIn | input | 1 | Serial configuration data in |
| cfgOut | output | 1 | Serial configuration data out (word bit 0) |
| lutIn | input | K | Logic inputs of the table |
| outFull | output | 1 | Full K-input table result |
| outHalf | output | 1 | Lower-half (K-1)-input result, 0 when not fracturable |

## Verification
The bench uses the default build: K=4, fracturable, input 2 force-high, input 3 force-low, and two mode bits. This single build covers both gate kinds, the ascending mode-bit order and the split output. Every combination of the two mode bits is paired with random tables and swept over all sixteen input patterns. The split output is checked while the top input is pinned and while it is free. The chain is checked bit by bit as it streams out an old word, and again while the enable is held low with the data pin toggling.

// File: rtl/fraclut_pkg.sv
package fraclut_pkg;

  localparam int MAX_IN = 16;

  typedef enum logic [1:0] {
    TAG_PASS = 2'd0,
    TAG_LOW  = 2'd1,
    TAG_HIGH = 2'd2
  } inTag_e;

  typedef struct packed {
    logic shift;
  } cfgStrobe_t;

  function automatic logic isGated(input logic [1:0] tag);
    return (tag == TAG_LOW) || (tag == TAG_HIGH);
  endfunction

  function automatic int countGated(input logic [2*MAX_IN-1:0] tags, input int k);
    int n;
    n = 0;
    for (int i = 0; i < k; i++) begin
      if (isGated(tags[2*i +: 2])) n++;
    end
    return n;
  endfunction

  function automatic int modeSlot(input logic [2*MAX_IN-1:0] tags, input int idx);
    int n;
    n = 0;
    for (int i = 0; i < idx; i++) begin
      if (isGated(tags[2*i +: 2])) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/fraclut_cfg_ctrl.sv
module fraclut_cfg_ctrl
  import fraclut_pkg::*;
(
  input  logic       cfgEn,
  output cfgStrobe_t strobe
);
  always_comb begin
    strobe.shift = cfgEn;
  end
endmodule

// File: rtl/fraclut_cfg_chain.sv
module fraclut_cfg_chain
  import fraclut_pkg::*;
#(
  parameter int CFG_W = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobe_t       strobe,
  input  logic             cfgIn,
  output logic [CFG_W-1:0] cfgWord,
  output logic             cfgOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWord <= '0;
    end else if (strobe.shift) begin
      cfgWord <= {cfgIn, cfgWord[CFG_W-1:1]};
    end
  end

  assign cfgOut = cfgWord[0];
endmodule

// File: rtl/fraclut_in_gate.sv
module fraclut_in_gate
  import fraclut_pkg::*;
#(
  parameter int                   K          = 4,
  parameter int                   MODE_SLOTS = 2,
  parameter logic [2*MAX_IN-1:0]  TAGS_EXT   = '0
) (
  input  logic [K-1:0]          lutIn,
  input  logic [MODE_SLOTS-1:0] modeBits,
  output logic [K-1:0]          selOut
);
  for (genvar i = 0; i < K; i++) begin : g_in
    localparam logic [1:0] TAG  = TAGS_EXT[2*i +: 2];
    localparam int         SLOT = modeSlot(TAGS_EXT, i);
    if (TAG == TAG_LOW) begin : g_and
      assign selOut[i] = lutIn[i] & modeBits[SLOT];
    end else if (TAG == TAG_HIGH) begin : g_or
      assign selOut[i] = lutIn[i] | modeBits[SLOT];
    end else begin : g_pass
      assign selOut[i] = lutIn[i];
    end
  end
endmodule

// File: rtl/fraclut_mux_tree.sv
module fraclut_mux_tree #(
  parameter int K = 4
) (
  input  logic [(1<<K)-1:0] leaves,
  input  logic [K-1:0]      sel,
  output logic              fullOut,
  output logic              halfOut
);
  localparam int NODES = (1 << (K+1)) - 1;

  logic [NODES-1:0] node;

  assign node[(1<<K)-1:0] = leaves;

  for (genvar l = 0; l < K; l++) begin : g_lvl
    localparam int SRC = (1 << (K+1)) - (1 << (K-l+1));
    localparam int DST = (1 << (K+1)) - (1 << (K-l));
    for (genvar j = 0; j < (1 << (K-l-1)); j++) begin : g_node
      assign node[DST+j] = sel[l] ? node[SRC+2*j+1] : node[SRC+2*j];
    end
  end

  assign fullOut = node[NODES-1];
  assign halfOut = node[(1 << (K+1)) - 4];
endmodule

// File: rtl/fraclut_top.sv
module fraclut_top
  import fraclut_pkg::*;
#(
  parameter int           K      = 4,
  parameter bit           FRAC   = 1'b1,
  parameter int           MODE_W = 2,
  parameter logic [2*K-1:0] IN_TAG = {2'd1, 2'd2, 2'd0, 2'd0}
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgEn,
  input  logic         cfgIn,
  output logic         cfgOut,
  input  logic [K-1:0] lutIn,
  output logic         outFull,
  output logic         outHalf
);
  localparam int                  TABLE_N    = 1 << K;
  localparam int                  CFG_W      = TABLE_N + MODE_W;
  localparam int                  MODE_SLOTS = (MODE_W > 0) ? MODE_W : 1;
  localparam logic [2*MAX_IN-1:0] TAGS_EXT   = (2*MAX_IN)'(IN_TAG);
  localparam int                  N_GATED    = countGated(TAGS_EXT, K);

  if (K < 2 || K > MAX_IN) begin : g_bad_k
    $error("fraclut_top: K out of range");
  end
  if (MODE_W != N_GATED) begin : g_bad_mode
    $error("fraclut_top: mode bit count differs from gated input count");
  end
  if (!FRAC && (MODE_W != 0)) begin : g_bad_frac
    $error("fraclut_top: a plain table takes no mode bits");
  end

  cfgStrobe_t              strobe;
  logic [CFG_W-1:0]        cfgWord;
  logic [MODE_SLOTS-1:0]   modeBits;
  logic [K-1:0]            selBus;
  logic                    halfRaw;

  fraclut_cfg_ctrl u_ctrl (
    .cfgEn  (cfgEn),
    .strobe (strobe)
  );

  fraclut_cfg_chain #(.CFG_W(CFG_W)) u_chain (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgIn   (cfgIn),
    .cfgWord (cfgWord),
    .cfgOut  (cfgOut)
  );

  if (MODE_W > 0) begin : g_mode
    assign modeBits = cfgWord[CFG_W-1:TABLE_N];
  end else begin : g_nomode
    assign modeBits = '0;
  end

  fraclut_in_gate #(
    .K          (K),
    .MODE_SLOTS (MODE_SLOTS),
    .TAGS_EXT   (TAGS_EXT)
  ) u_gate (
    .lutIn    (lutIn),
    .modeBits (modeBits),
    .selOut   (selBus)
  );

  fraclut_mux_tree #(.K(K)) u_tree (
    .leaves  (cfgWord[TABLE_N-1:0]),
    .sel     (selBus),
    .fullOut (outFull),
    .halfOut (halfRaw)
  );

  if (FRAC) begin : g_split
    assign outHalf = halfRaw;
  end else begin : g_single
    assign outHalf = 1'b0;
  end
endmodule

// File: rtl/fraclut_chk.sv
module fraclut_chk
  import fraclut_pkg::*;
#(
  parameter int             K      = 4,
  parameter bit             FRAC   = 1'b1,
  parameter int             MODE_W = 2,
  parameter logic [2*K-1:0] IN_TAG = {2'd1, 2'd2, 2'd0, 2'd0}
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      cfgEn,
  input logic                      cfgIn,
  input logic                      cfgOut,
  input logic [K-1:0]              lutIn,
  input logic                      outFull,
  input logic                      outHalf,
  input logic [(1<<K)+MODE_W-1:0]  cfgWord
);
  localparam int TABLE_N = 1 << K;

  logic [K-1:0] refIdx;

  always_comb begin
    int slot;
    slot   = 0;
    refIdx = lutIn;
    for (int i = 0; i < K; i++) begin
      if (IN_TAG[2*i +: 2] == TAG_LOW) begin
        if (!cfgWord[TABLE_N + slot]) refIdx[i] = 1'b0;
        slot++;
      end else if (IN_TAG[2*i +: 2] == TAG_HIGH) begin
        if (cfgWord[TABLE_N + slot]) refIdx[i] = 1'b1;
        slot++;
      end
    end
  end

  // R1 R2 R3 R4: full output indexes the table with the gated inputs
  a_r1_full_index: assert property (@(posedge clk) disable iff (!rstN)
    outFull == cfgWord[refIdx]);

  // R5: split output follows the lower half of the table
  a_r5_half_index: assert property (@(posedge clk) disable iff (!rstN)
    FRAC |-> (outHalf == cfgWord[refIdx[K-2:0]]));

  // R6: serial data lands in the top word bit
  a_r6_shift_in: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |=> cfgWord[TABLE_N+MODE_W-1] == $past(cfgIn));

  // R7: word frozen while the enable is low
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |=> $stable(cfgWord));

  // R8: scan-out moves to the next bit after a shift
  a_r8_scan_out: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |=> cfgOut == $past(cfgWord[1]));

  // R9: an all-zero word drives both outputs low
  a_r9_zero_word: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWord == '0) |-> (!outFull && !outHalf && !cfgOut));
endmodule

bind fraclut_top fraclut_chk #(
  .K      (K),
  .FRAC   (FRAC),
  .MODE_W (MODE_W),
  .IN_TAG (IN_TAG)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cfgEn   (cfgEn),
  .cfgIn   (cfgIn),
  .cfgOut  (cfgOut),
  .lutIn   (lutIn),
  .outFull (outFull),
  .outHalf (outHalf),
  .cfgWord (cfgWord)
);

// File: tb/fraclut_top_tb.sv
`timescale 1ns/1ps
module fraclut_top_tb;
  localparam int K      = 4;
  localparam int MODE_W = 2;
  localparam int CFG_W  = (1 << K) + MODE_W;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgEn = 1'b0;
  logic         cfgIn = 1'b0;
  logic         cfgOut;
  logic [K-1:0] lutIn = '0;
  logic         outFull;
  logic         outHalf;

  int total = 0;
  int bad   = 0;
  logic [CFG_W-1:0] curWord = '0;

  always #2.5 clk = ~clk;

  fraclut_top u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .cfgEn   (cfgEn),
    .cfgIn   (cfgIn),
    .cfgOut  (cfgOut),
    .lutIn   (lutIn),
    .outFull (outFull),
    .outHalf (outHalf)
  );

  // {mode[1:0], table[15:0], lutIn[3:0], expFull, expHalf}
  localparam logic [23:0] VEC [8] = '{
    {2'b10, 16'h8000, 4'hF, 1'b1, 1'b0},
    {2'b10, 16'h8000, 4'h7, 1'b0, 1'b0},
    {2'b00, 16'h8080, 4'hF, 1'b1, 1'b1},
    {2'b11, 16'h0010, 4'h0, 1'b1, 1'b1},
    {2'b11, 16'h0010, 4'h8, 1'b0, 1'b1},
    {2'b10, 16'h0001, 4'h0, 1'b1, 1'b1},
    {2'b10, 16'hFFFE, 4'h0, 1'b0, 1'b0},
    {2'b01, 16'h0100, 4'h8, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic [K-1:0] effIdx(input logic [CFG_W-1:0] w, input logic [K-1:0] p);
    logic [K-1:0] e;
    e = p;
    e[2] = p[2] | w[16];
    e[3] = p[3] & w[17];
    return e;
  endfunction

  task automatic loadWord(input logic [CFG_W-1:0] w, input bit chkOut);
    for (int i = 0; i < CFG_W; i++) begin
      @(negedge clk);
      if (chkOut) check("R8 scan-out", cfgOut, curWord[i]);
      cfgEn = 1'b1;
      cfgIn = w[i];
    end
    @(negedge clk);
    cfgEn = 1'b0;
    cfgIn = 1'b0;
    curWord = w;
  endtask

  task automatic sweep(input string tag);
    for (int p = 0; p < (1 << K); p++) begin
      logic [K-1:0] e;
      lutIn = K'(p);
      #1;
      e = effIdx(curWord, K'(p));
      check({tag, " R1 full"}, outFull, curWord[e]);
      check({tag, " R5 half"}, outHalf, curWord[e[K-2:0]]);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    for (int p = 0; p < (1 << K); p++) begin
      lutIn = K'(p);
      #1;
      check("R9 reset full", outFull, 1'b0);
      check("R9 reset half", outHalf, 1'b0);
    end
    check("R9 reset scan-out", cfgOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 after release", outFull, 1'b0);

    // vector table: R2 R3 R4 R6 directed cases
    for (int v = 0; v < 8; v++) begin
      logic [23:0] e;
      e = VEC[v];
      if (curWord != e[23:6]) loadWord(e[23:6], 1'b0);
      lutIn = e[5:2];
      #1;
      check("R2 R3 R4 R6 vector full", outFull, e[1]);
      check("R2 R3 R4 R6 vector half", outHalf, e[0]);
    end

    // random tables under every mode setting, all input patterns
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 2; r++) begin
        logic [CFG_W-1:0] w;
        w = {2'(m), 16'($urandom())};
        loadWord(w, 1'b1);
        sweep("R1 R2 R3 R5 sweep");
      end
    end

    // R7: enable low, data pin toggling
    begin
      logic [CFG_W-1:0] held;
      held = curWord;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        cfgIn = ~cfgIn;
      end
      cfgIn = 1'b0;
      @(negedge clk);
      check("R7 scan-out held", cfgOut, held[0]);
      sweep("R7 hold");
    end

    // R8: stream old word out while loading a new one
    loadWord(18'h2A5F0, 1'b1);
    check("R8 final scan-out", cfgOut, 1'b0);
    loadWord(18'h3FFFF, 1'b1);
    check("R8 all-ones scan-out", cfgOut, 1'b1);
    sweep("R3 R4 all-ones");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule